// File: doc/BRIEF.md
# Memory-Mapped GPIO Line Bank

This block is a register-addressed port for up to 64 general-purpose I/O lines. It is reached over a plain 64-bit register bus. A request is a select pulse with an address, a write flag and write data. One cycle after the request the block answers with a ready pulse and the read data. Software reads the sampled pad levels through an input word. It changes the output latches only through two strobe words: a 1 written to the set word raises that line's latch, and a 1 written to the clear word lowers it. A constant word tells software how many lines are present and where their interrupt vectors begin.

Each line has its own configuration word, which holds four controls:
- output enable;
- a polarity inversion, applied to the driven value and to the sampled value alike;
- an open-drain mode, in which the pad is only ever pulled low and the driven sense is reversed compared with push-pull;
- a function-owner field. When this field is nonzero, another on-chip function owns the pad. The bank then releases the pad and does not let set or clear writes change that line's latch.

The bank drives pad output and pad output-enable and receives pad input. Glitch filtering, interrupt generation, a second bank and pad electrical behaviour live in other blocks.

Top module: `gpio_line_bank`

## Requirements
- R1: After reset every output latch and every configuration word is 0, so pad_oe and pad_out are all 0 and every line is an input.
- R2: A write to offset 0x8 sets the latch of every line whose data bit is 1 and leaves lines whose bit is 0 unchanged. A read of 0x8 or of 0x10 returns the latch vector in bits NUM_LINES-1:0.
- R3: A write to offset 0x10 clears the latch of every line whose data bit is 1 and leaves lines whose bit is 0 unchanged.
- R4: A read of offset 0x90 returns the line count in bits 7:0 and the interrupt vector base in bits 15:8, with all higher bits 0.
- R5: The configuration word of line n is at 0x400 + 8*n. Only bit 0 (output enable), bit 1 (invert), bit 12 (open-drain) and bits 25:16 (function owner) are stored, and all other bits read back as 0.
- R6: For a line it owns, in push-pull mode (bit 12 = 0), the bank drives pad_out = latch XOR invert and pad_oe = output enable.
- R7: For a line it owns, in open-drain mode, the bank holds pad_out at 0 and drives pad_oe = output enable AND (latch XOR invert), so the pad is pulled low exactly when the inverted-sense output is low.
- R8: While a line's function-owner field is nonzero, its pad_out and pad_oe are 0 and writes to the set and clear words leave its latch unchanged.
- R9: Each pad input passes through two flip-flops. A read of offset 0x0 then returns the synchronised level XOR the line's invert bit.
- R10: bus_ready is high in exactly the cycle after each request. Writes to offsets 0x0 and 0x90 change nothing.
- R11: Data bits at and above NUM_LINES read as 0 and are ignored on write. Unmapped or unaligned addresses, including configuration addresses for lines at or above NUM_LINES, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Completion pulse, one cycle after bus_sel |
| pad_in | input | NUM_LINES | Asynchronous pad levels |
| pad_out | output | NUM_LINES | Pad drive value |
| pad_oe | output | NUM_LINES | Pad driver enable |

## Verification
The hardest state to reach from the ports is a line taken over by another function while its latch holds a value that differs from the one a set or clear write would produce. Showing that the latch really stayed frozen requires releasing the line afterwards and observing the pad. The bench does exactly this. It loads line 3's latch, claims the line through its owner field, and hammers the set and clear words. It then reads the latch and, after releasing ownership with output enable on, checks that the pad shows the value held from before the claim. Every line is also swept through all eight enable, invert and open-drain combinations, with both latch values, against an arithmetic model of the pad drive.

// File: rtl/glb_pkg.sv
package glb_pkg;

   localparam int unsigned WORD_W    = 64;
   localparam int unsigned FN_W      = 10;

   localparam int unsigned OFS_RX    = 'h000;
   localparam int unsigned OFS_SET   = 'h008;
   localparam int unsigned OFS_CLR   = 'h010;
   localparam int unsigned OFS_CONST = 'h090;
   localparam int unsigned OFS_CFG   = 'h400;
   localparam int unsigned CFG_STRIDE = 8;

   localparam int unsigned BIT_OE    = 0;
   localparam int unsigned BIT_INV   = 1;
   localparam int unsigned BIT_OD    = 12;
   localparam int unsigned BIT_FN_LO = 16;

   typedef struct packed {
      logic [FN_W-1:0] fn;
      logic            od;
      logic            inv;
      logic            oe;
   } line_cfg_t;

   typedef enum logic [2:0] {
      RK_NONE  = 3'd0,
      RK_RX    = 3'd1,
      RK_SET   = 3'd2,
      RK_CLR   = 3'd3,
      RK_CONST = 3'd4,
      RK_CFG   = 3'd5
   } reg_kind_t;

   function automatic line_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
      line_cfg_t c;
      c.oe  = w[BIT_OE];
      c.inv = w[BIT_INV];
      c.od  = w[BIT_OD];
      c.fn  = w[BIT_FN_LO +: FN_W];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] cfg_to_word(input line_cfg_t c);
      logic [WORD_W-1:0] w;
      w = '0;
      w[BIT_OE]             = c.oe;
      w[BIT_INV]            = c.inv;
      w[BIT_OD]             = c.od;
      w[BIT_FN_LO +: FN_W]  = c.fn;
      return w;
   endfunction

endpackage

// File: rtl/glb_in_sync.sv
module glb_in_sync #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] meta_q;
   logic [WIDTH-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= d;
         sync_q <= meta_q;
      end
   end

   assign q = sync_q;

   // warm-up counter so the two-cycle history never reaches into reset
   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             warm_q <= '0;
      else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
   end

   a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/glb_addr_decode.sv
module glb_addr_decode
   import glb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned IDX_W     = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_t         kind,
   output logic [IDX_W-1:0]  cfg_idx
);

   localparam logic [ADDR_W-1:0] A_RX    = ADDR_W'(OFS_RX);
   localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_CONST = ADDR_W'(OFS_CONST);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_CFG_END = ADDR_W'(OFS_CFG + CFG_STRIDE * NUM_LINES);

   logic [ADDR_W-1:0] cfg_off;
   assign cfg_off = addr - A_CFG;

   always_comb begin
      kind    = RK_NONE;
      cfg_idx = '0;
      if (addr[2:0] == 3'b000) begin
         if      (addr == A_RX)    kind = RK_RX;
         else if (addr == A_SET)   kind = RK_SET;
         else if (addr == A_CLR)   kind = RK_CLR;
         else if (addr == A_CONST) kind = RK_CONST;
         else if (addr >= A_CFG && addr < A_CFG_END) begin
            kind    = RK_CFG;
            cfg_idx = cfg_off[3 +: IDX_W];
         end
      end
   end

endmodule

// File: rtl/glb_line_cell.sv
module glb_line_cell
   import glb_pkg::*;
#(
   parameter bit HAS_OPEN_DRAIN = 1'b1,
   parameter bit HAS_FUNC_SEL   = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      set_stb,
   input  logic      clr_stb,
   input  logic      cfg_we,
   input  line_cfg_t cfg_in,
   input  logic      pin_sync,
   output logic      latch_q,
   output line_cfg_t cfg_q,
   output logic      rx_bit,
   output logic      pad_out,
   output logic      pad_oe
);

   line_cfg_t cfg_r;
   logic      owned;
   logic      drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_r <= '0;
      else if (cfg_we) cfg_r <= cfg_in;
   end

   // Variant selection: unsupported fields are tied off and read as 0
   always_comb begin
      cfg_q     = cfg_r;
      cfg_q.od  = HAS_OPEN_DRAIN ? cfg_r.od : 1'b0;
      cfg_q.fn  = HAS_FUNC_SEL   ? cfg_r.fn : '0;
   end

   assign owned = |cfg_q.fn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                latch_q <= 1'b0;
      else if (!owned && set_stb) latch_q <= 1'b1;
      else if (!owned && clr_stb) latch_q <= 1'b0;
   end

   assign drive  = latch_q ^ cfg_q.inv;
   assign rx_bit = pin_sync ^ cfg_q.inv;

   generate
      if (HAS_OPEN_DRAIN) begin : g_od
         always_comb begin
            if (owned) begin
               pad_out = 1'b0;
               pad_oe  = 1'b0;
            end else if (cfg_q.od) begin
               pad_out = 1'b0;
               pad_oe  = cfg_q.oe & drive;
            end else begin
               pad_out = drive;
               pad_oe  = cfg_q.oe;
            end
         end
      end else begin : g_pp
         always_comb begin
            pad_out = owned ? 1'b0 : drive;
            pad_oe  = owned ? 1'b0 : cfg_q.oe;
         end
      end
   endgenerate

   a_r8_owned_pad_idle: assert property (@(posedge clk) disable iff (!rst_n)
      owned |-> (!pad_out && !pad_oe));
   a_r8_owned_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      owned |=> (latch_q == $past(latch_q)));
   a_r7_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.od |-> !pad_out);
   a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && !owned) |=> latch_q);
   a_r3_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb && !owned) |=> !latch_q);

endmodule

// File: rtl/glb_read_port.sv
module glb_read_port
   import glb_pkg::*;
#(
   parameter int unsigned NUM_LINES = 64,
   parameter int unsigned IDX_W     = 6
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bus_sel,
   input  logic                                bus_we,
   input  reg_kind_t                           kind,
   input  logic [IDX_W-1:0]                    cfg_idx,
   input  logic [NUM_LINES-1:0]                rx_vec,
   input  logic [NUM_LINES-1:0]                latch_vec,
   input  line_cfg_t [NUM_LINES-1:0]           cfg_all,
   input  logic [WORD_W-1:0]                   const_word,
   output logic                                bus_ready,
   output logic [WORD_W-1:0]                   bus_rdata
);

   logic [WORD_W-1:0] rd_val;

   always_comb begin
      unique case (kind)
         RK_RX:          rd_val = WORD_W'(rx_vec);
         RK_SET, RK_CLR: rd_val = WORD_W'(latch_vec);
         RK_CONST:       rd_val = const_word;
         RK_CFG:         rd_val = cfg_to_word(cfg_all[cfg_idx]);
         default:        rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ready <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ready <= bus_sel;
         bus_rdata <= (bus_sel && !bus_we) ? rd_val : '0;
      end
   end

endmodule

// File: rtl/gpio_line_bank.sv
module gpio_line_bank
   import glb_pkg::*;
#(
   parameter int unsigned NUM_LINES      = 64,
   parameter int unsigned ADDR_W         = 16,
   parameter logic [7:0]  VEC_BASE       = 8'h30,
   parameter bit          HAS_OPEN_DRAIN = 1'b1,
   parameter bit          HAS_FUNC_SEL   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [63:0]          bus_wdata,
   output logic [63:0]          bus_rdata,
   output logic                 bus_ready,
   input  logic [NUM_LINES-1:0] pad_in,
   output logic [NUM_LINES-1:0] pad_out,
   output logic [NUM_LINES-1:0] pad_oe
);

   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   generate
      if (NUM_LINES < 1 || NUM_LINES > 64) begin : g_bad_lines
         $error("gpio_line_bank: NUM_LINES must lie in 1..64");
      end
      if (ADDR_W < 12 || ADDR_W > 32) begin : g_bad_addr
         $error("gpio_line_bank: ADDR_W must lie in 12..32");
      end
   endgenerate

   reg_kind_t                kind;
   logic [IDX_W-1:0]         cfg_idx;
   logic [NUM_LINES-1:0]     pin_sync;
   logic [NUM_LINES-1:0]     rx_vec;
   logic [NUM_LINES-1:0]     latch_vec;
   line_cfg_t [NUM_LINES-1:0] cfg_all;
   logic                     wr_any;
   line_cfg_t                cfg_wr;
   logic [WORD_W-1:0]        const_word;

   assign wr_any     = bus_sel && bus_we;
   assign cfg_wr     = cfg_from_word(bus_wdata);
   assign const_word = {48'h0, VEC_BASE, 8'(NUM_LINES)};

   glb_addr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) u_decode (
      .addr    (bus_addr),
      .kind    (kind),
      .cfg_idx (cfg_idx)
   );

   glb_in_sync #(.WIDTH(NUM_LINES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         logic set_i, clr_i, cfg_i;
         assign set_i = wr_any && (kind == RK_SET) && bus_wdata[i];
         assign clr_i = wr_any && (kind == RK_CLR) && bus_wdata[i];
         assign cfg_i = wr_any && (kind == RK_CFG) && (cfg_idx == IDX_W'(i));

         glb_line_cell #(
            .HAS_OPEN_DRAIN (HAS_OPEN_DRAIN),
            .HAS_FUNC_SEL   (HAS_FUNC_SEL)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_stb  (set_i),
            .clr_stb  (clr_i),
            .cfg_we   (cfg_i),
            .cfg_in   (cfg_wr),
            .pin_sync (pin_sync[i]),
            .latch_q  (latch_vec[i]),
            .cfg_q    (cfg_all[i]),
            .rx_bit   (rx_vec[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i])
         );
      end
   endgenerate

   glb_read_port #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) u_read (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .kind       (kind),
      .cfg_idx    (cfg_idx),
      .rx_vec     (rx_vec),
      .latch_vec  (latch_vec),
      .cfg_all    (cfg_all),
      .const_word (const_word),
      .bus_ready  (bus_ready),
      .bus_rdata  (bus_rdata)
   );

   a_r10_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel |=> bus_ready);
   a_r10_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |-> $past(bus_sel));
   a_r10_write_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we) |=> (bus_rdata == '0));
   a_r11_latch_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && (kind == RK_SET || kind == RK_CLR)) |=> $stable(latch_vec));

endmodule

// File: tb/gpio_line_bank_bench.sv
`timescale 1ns/1ps
module gpio_line_bank_bench;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic [63:0] bus_rdata;
   logic        bus_ready;
   logic [N-1:0] pad_in = '0;
   logic [N-1:0] pad_out;
   logic [N-1:0] pad_oe;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   gpio_line_bank #(
      .NUM_LINES (N),
      .ADDR_W    (16),
      .VEC_BASE  (8'h5A)
   ) u_gpio_line_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_ready (bus_ready),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   // reference model
   logic [N-1:0] m_latch = '0;
   logic [N-1:0] m_oe = '0, m_inv = '0, m_od = '0;
   logic [9:0]   m_fn [N];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      chk("R10 ready after write", {63'd0, bus_ready}, 64'd1);
   endtask

   task automatic bus_rd(input logic [15:0] a, output logic [63:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      chk("R10 ready after read", {63'd0, bus_ready}, 64'd1);
      d = bus_rdata;
   endtask

   function automatic logic [N-1:0] owned_mask();
      logic [N-1:0] m;
      for (int i = 0; i < N; i++) m[i] = (m_fn[i] != 10'd0);
      return m;
   endfunction

   task automatic wr_cfg(input int ln, input logic oe, input logic inv,
                         input logic od, input logic [9:0] fn);
      m_oe[ln] = oe; m_inv[ln] = inv; m_od[ln] = od; m_fn[ln] = fn;
      bus_wr(16'h400 + 16'(8 * ln),
             {38'd0, fn, 3'd0, od, 10'd0, inv, oe});
   endtask

   task automatic wr_set(input logic [63:0] d);
      m_latch = m_latch | (d[N-1:0] & ~owned_mask());
      bus_wr(16'h008, d);
   endtask

   task automatic wr_clr(input logic [63:0] d);
      m_latch = m_latch & ~(d[N-1:0] & ~owned_mask());
      bus_wr(16'h010, d);
   endtask

   task automatic chk_pads(input string req);
      logic [N-1:0] eo, ee;
      for (int i = 0; i < N; i++) begin
         logic dv;
         dv = m_latch[i] ^ m_inv[i];
         if (m_fn[i] != 10'd0) begin eo[i] = 1'b0; ee[i] = 1'b0; end
         else if (m_od[i])     begin eo[i] = 1'b0; ee[i] = m_oe[i] & dv; end
         else                  begin eo[i] = dv;   ee[i] = m_oe[i]; end
      end
      chk({req, " pad_out"}, 64'(pad_out), 64'(eo));
      chk({req, " pad_oe"},  64'(pad_oe),  64'(ee));
   endtask

   initial begin
      logic [63:0] rd;
      logic [7:0]  inv_pats [3];
      logic [7:0]  in_pats  [4];
      inv_pats = '{8'h00, 8'hFF, 8'h3C};
      in_pats  = '{8'h00, 8'hFF, 8'hA5, 8'h1E};
      for (int i = 0; i < N; i++) m_fn[i] = 10'd0;

      pad_in = 8'hFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 pad_oe after reset", 64'(pad_oe), 64'd0);
      chk("R1 pad_out after reset", 64'(pad_out), 64'd0);
      bus_rd(16'h008, rd); chk("R1 latch after reset", rd, 64'd0);
      for (int i = 0; i < N; i++) begin
         bus_rd(16'h400 + 16'(8 * i), rd);
         chk("R1 cfg after reset", rd, 64'd0);
      end
      pad_in = 8'h00;

      // R4 constant word
      bus_rd(16'h090, rd); chk("R4 constant word", rd, 64'h5A08);

      // R5 config field storage
      bus_wr(16'h410, 64'hFFFF_FFFF_FFFF_FFFF);
      bus_rd(16'h410, rd); chk("R5 cfg readback", rd, 64'h03FF_1003);
      m_oe[2] = 1'b1; m_inv[2] = 1'b1; m_od[2] = 1'b1; m_fn[2] = 10'h3FF;
      chk_pads("R8 owned after all-ones cfg");
      wr_cfg(2, 1'b0, 1'b0, 1'b0, 10'd0);
      bus_rd(16'h410, rd); chk("R5 cfg cleared", rd, 64'd0);

      // R11 unmapped / out-of-range / unaligned
      bus_wr(16'h440, 64'hFFFF_FFFF_FFFF_FFFF);
      bus_rd(16'h440, rd); chk("R11 cfg beyond lines", rd, 64'd0);
      bus_rd(16'h438, rd); chk("R11 last line untouched", rd, 64'd0);
      bus_rd(16'h088, rd); chk("R11 unmapped read", rd, 64'd0);
      bus_wr(16'h40C, 64'h1);
      bus_rd(16'h408, rd); chk("R11 unaligned write ignored", rd, 64'd0);

      // R2 / R3 set and clear patterns
      wr_set(64'hA5);  bus_rd(16'h008, rd); chk("R2 set A5", rd, 64'(m_latch));
      wr_set(64'h0F);  bus_rd(16'h008, rd); chk("R2 set 0F keeps others", rd, 64'hAF);
      wr_clr(64'h81);  bus_rd(16'h010, rd); chk("R3 clear 81", rd, 64'h2E);
      wr_clr(64'h00);  bus_rd(16'h008, rd); chk("R3 clear zero no effect", rd, 64'h2E);
      wr_set(64'hFFFF_FFFF_FFFF_FF00);
      bus_rd(16'h008, rd); chk("R11 upper set bits ignored", rd, 64'h2E);

      // R10 writes to read-only words
      bus_wr(16'h000, 64'hFF);
      bus_wr(16'h090, 64'hFFFF);
      bus_rd(16'h008, rd); chk("R10 ro writes leave latch", rd, 64'h2E);
      bus_rd(16'h090, rd); chk("R10 constant unchanged", rd, 64'h5A08);

      // R6 / R7 sweep: every line, every oe/inv/od combination, both latch values
      for (int ln = 0; ln < N; ln++) begin
         for (int c = 0; c < 8; c++) begin
            wr_cfg(ln, c[0], c[1], c[2], 10'd0);
            wr_set(64'(1) << ln);
            chk_pads(c[2] ? "R7 sweep latch1" : "R6 sweep latch1");
            wr_clr(64'(1) << ln);
            chk_pads(c[2] ? "R7 sweep latch0" : "R6 sweep latch0");
         end
         wr_cfg(ln, 1'b0, 1'b0, 1'b0, 10'd0);
      end

      // R8 ownership freezes latch and idles pads
      wr_clr(64'hFF);
      wr_set(64'h08);
      wr_cfg(3, 1'b1, 1'b0, 1'b0, 10'h155);
      chk_pads("R8 owned pads idle");
      wr_clr(64'hFF);
      bus_rd(16'h008, rd); chk("R8 clear ignored on owned", rd, 64'h08);
      wr_set(64'hFF);
      bus_rd(16'h008, rd); chk("R8 set only unowned", rd, 64'hFF);
      wr_clr(64'hFF);
      bus_rd(16'h008, rd); chk("R8 owned bit held", rd, 64'h08);
      wr_cfg(3, 1'b1, 1'b0, 1'b0, 10'd0);
      chk("R8 released pad shows held latch", 64'(pad_out[3]), 64'd1);
      chk_pads("R8 released pads");
      wr_clr(64'hFF);

      // R9 input sampling with inversion
      for (int p = 0; p < 3; p++) begin
         for (int ln = 0; ln < N; ln++)
            wr_cfg(ln, 1'b0, inv_pats[p][ln], 1'b0, 10'd0);
         for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            pad_in = in_pats[q];
            repeat (2) @(negedge clk);
            bus_rd(16'h000, rd);
            chk("R9 input word", rd, 64'(in_pats[q] ^ inv_pats[p]));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule